// File: doc/BRIEF.md
# Selectable Channel Summing Mixer

A filter bank delivers its per-channel results to this block one at a time. Each result comes with a valid strobe and a channel index. The block keeps a membership mask that says which channels go to the audio output. It adds up only the member channels of each frame, scales the total down, and emits one signed output sample per frame. The sample for the frame just ended appears on the cycle after each frame-start pulse.

A small command port edits the mask and controls the output. The commands are:
- clear the whole selection;
- add an inclusive index range to the selection;
- remove an inclusive index range from the selection;
- stop the output (mute);
- start the output again.

Mask edits are staged and take effect only at the next frame boundary, so a frame is never summed with two different selections. Muting keeps the frame timing and leaves the selection as it is.

Top module: `band_mix`

## Requirements
- R1: On the cycle after each `frame_start` pulse, `out_valid` is high for exactly one cycle. At that point `out_sample` is floor(S/64) saturated to a signed 16-bit value, where S is the signed sum of member-channel strobes accepted since the previous `frame_start`. The previous `frame_start` cycle itself belongs to that frame.
- R2: Opcode 1 (clear) empties the selection.
- R3: Opcode 2 (add) sets every index from `cmd_first` to `cmd_last` inclusive. Indices already selected stay selected.
- R4: Opcode 3 (remove) drops every index from `cmd_first` to `cmd_last` inclusive. Other indices are untouched.
- R5: Opcode 5 (stop) makes each later frame emit a zero sample. `out_valid` still pulses once per frame, and the selection is kept.
- R6: Opcode 4 (start) resumes normal output with the selection unchanged.
- R7: An add or remove command with `cmd_first` greater than `cmd_last` has no effect. Opcodes 0, 6 and 7 have no effect.
- R8: A selection change made inside a frame applies from the next `frame_start`. The frame already in progress keeps the old selection.
- R9: After reset the selection is empty, output is enabled and `out_valid` is low.
- R10: All 40 channels at full scale cannot overflow. All at +32767 gives 20479, and all at -32768 gives -20480.
- R11: Strobes from unselected channels add nothing. Strobes with an index of 40 or more add nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Frame boundary pulse |
| ch_valid | input | 1 | Channel sample strobe |
| ch_idx | input | 6 | Index of the strobed channel |
| ch_data | input | 16 | Signed channel sample |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 1 clear, 2 add, 3 remove, 4 start, 5 stop |
| cmd_first | input | 6 | First index of the range |
| cmd_last | input | 6 | Last index of the range, inclusive |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Signed scaled mix |

## Verification
The mixed sample is registered once. It is due on the first clock edge after the `frame_start` edge, and the bench reads it at the falling edge that follows. The bench also confirms that `out_valid` is low again one cycle later.

A command becomes visible only through the sample of a frame that started after the command. The bench therefore keeps a staged mask and an active mask of its own and copies one to the other at each frame pulse. Each frame's sum is checked at the pulse after the frame, and a mid-frame edit is expected to show up two frame pulses later.

// File: rtl/band_mix.sv
module band_mix #(
  parameter int NCH   = 40,
  parameter int IN_W  = 16,
  parameter int OUT_W = 16,
  parameter int IDX_W = 6,
  parameter int OP_W  = 3,
  parameter int SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    ch_valid,
  input  logic [IDX_W-1:0]        ch_idx,
  input  logic signed [IN_W-1:0]  ch_data,
  input  logic                    cmd_valid,
  input  logic [OP_W-1:0]         cmd_op,
  input  logic [IDX_W-1:0]        cmd_first,
  input  logic [IDX_W-1:0]        cmd_last,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_sample
);
  localparam int ACC_W = IN_W + $clog2(NCH);
  localparam logic [OP_W-1:0] OP_CLEAR = OP_W'(1);
  localparam logic [OP_W-1:0] OP_ADD   = OP_W'(2);
  localparam logic [OP_W-1:0] OP_DEL   = OP_W'(3);
  localparam logic [OP_W-1:0] OP_START = OP_W'(4);
  localparam logic [OP_W-1:0] OP_STOP  = OP_W'(5);
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((1 << (OUT_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] LO = -HI - ACC_W'(1);

  logic [NCH-1:0] pend_mask, act_mask, rng, use_mask;
  logic run;
  logic signed [ACC_W-1:0] acc, ch_ext, shr;
  logic signed [OUT_W-1:0] sat;
  logic range_ok, hit;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_rng
      assign rng[g] = (IDX_W'(g) >= cmd_first) && (IDX_W'(g) <= cmd_last);
    end
  endgenerate

  assign range_ok = cmd_first <= cmd_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_mask <= '0;
      run       <= 1'b1;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_CLEAR: pend_mask <= '0;
        OP_ADD:   if (range_ok) pend_mask <= pend_mask | rng;
        OP_DEL:   if (range_ok) pend_mask <= pend_mask & ~rng;
        OP_START: run <= 1'b1;
        OP_STOP:  run <= 1'b0;
        default: ;
      endcase
    end
  end

  assign use_mask = frame_start ? pend_mask : act_mask;
  assign hit      = ch_valid && |(use_mask & (NCH'(1) << ch_idx));
  assign ch_ext   = {{(ACC_W-IN_W){ch_data[IN_W-1]}}, ch_data};
  assign shr      = acc >>> SHIFT;
  assign sat      = (shr > HI) ? OUT_W'(HI) : (shr < LO) ? OUT_W'(LO) : shr[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_mask   <= '0;
      acc        <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (frame_start) begin
      act_mask   <= pend_mask;
      acc        <= hit ? ch_ext : '0;
      out_valid  <= 1'b1;
      out_sample <= run ? sat : '0;
    end else begin
      out_valid  <= 1'b0;
      if (hit) acc <= acc + ch_ext;
    end
  end
endmodule

module band_mix_chk #(
  parameter int NCH   = 40,
  parameter int OUT_W = 16,
  parameter int OP_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             cmd_valid,
  input logic [OP_W-1:0]  cmd_op,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_sample,
  input logic             run,
  input logic [NCH-1:0]   pend_mask,
  input logic [NCH-1:0]   act_mask
);
  AST_FRAME_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> out_valid); // R1
  AST_EMIT_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(frame_start)); // R1
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_W'(1)) |=> (pend_mask == '0)); // R2
  AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !run) |=> (out_sample == '0)); // R5
  AST_STOP_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_W'(5)) |=> $stable(pend_mask)); // R5
  AST_START_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_W'(4)) |=> $stable(pend_mask)); // R6
  AST_MASK_FROZEN_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_mask)); // R8
endmodule

bind band_mix band_mix_chk #(.NCH(NCH), .OUT_W(OUT_W), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .out_valid(out_valid), .out_sample(out_sample), .run(run),
  .pend_mask(pend_mask), .act_mask(act_mask));

// File: tb/sim_band_mix.sv
module sim_band_mix;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst_n, frame_start, ch_valid, cmd_valid;
  logic [5:0] ch_idx, cmd_first, cmd_last;
  logic signed [15:0] ch_data;
  logic [2:0] cmd_op;
  logic out_valid;
  logic signed [15:0] out_sample;

  band_mix u0 (.clk(clk), .rst_n(rst_n), .frame_start(frame_start), .ch_valid(ch_valid),
    .ch_idx(ch_idx), .ch_data(ch_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_first(cmd_first), .cmd_last(cmd_last), .out_valid(out_valid), .out_sample(out_sample));

  int tests = 0, fails = 0, k = 0, sum_m = 0;
  logic [39:0] pend_m = '0, act_m = '0;
  bit run_m = 1;
  string lbl = "R9";
  bit done = 0;

  task automatic chk(string r, int a, int e);
    tests++;
    if (a != e) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, a, e);
    end
  endtask

  function automatic int scale(int s);
    int v = s >>> 6;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic logic [39:0] rmask(int f, int l);
    logic [39:0] m = '0;
    for (int i = 0; i < 40; i++) if (i >= f && i <= l) m[i] = 1'b1;
    return m;
  endfunction

  task automatic model(int op, int f, int l);
    case (op)
      1: pend_m = '0;
      2: if (f <= l) pend_m = pend_m | rmask(f, l);
      3: if (f <= l) pend_m = pend_m & ~rmask(f, l);
      4: run_m = 1;
      5: run_m = 0;
      default: ;
    endcase
  endtask

  task automatic cmd(int op, int f, int l);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_first = 6'(f); cmd_last = 6'(l);
    model(op, f, l);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  // mode 0 pattern, 1 all max, 2 all min, 3 pattern plus out-of-range strobes
  task automatic frame(string r, int mode, int mop, int mf, int ml);
    int e;
    @(negedge clk);
    frame_start = 1;
    e = run_m ? scale(sum_m) : 0;
    act_m = pend_m; sum_m = 0;
    @(negedge clk);
    frame_start = 0;
    chk({lbl, " valid"}, int'(out_valid), 1);
    chk(lbl, int'(out_sample), e);
    lbl = r;
    k++;
    for (int c = 0; c < 40; c++) begin
      int d;
      d = (mode == 1) ? 32767 : (mode == 2) ? -32768 : int'($signed(16'(c * 2731 + k * 4099 + 123)));
      ch_valid = 1; ch_idx = 6'(c); ch_data = 16'(d);
      if (act_m[c]) sum_m += d;
      if (c == 20 && mop != 0) begin
        cmd_valid = 1; cmd_op = 3'(mop); cmd_first = 6'(mf); cmd_last = 6'(ml);
        model(mop, mf, ml);
      end else cmd_valid = 0;
      @(negedge clk);
      if (c == 0) chk("R1 single pulse", int'(out_valid), 0);
    end
    cmd_valid = 0;
    if (mode == 3)
      for (int c = 40; c < 64; c++) begin
        ch_valid = 1; ch_idx = 6'(c); ch_data = 16'(1000);
        @(negedge clk);
      end
    ch_valid = 0;
  endtask

  initial begin
    rst_n = 0; frame_start = 0; ch_valid = 0; cmd_valid = 0;
    ch_idx = 0; ch_data = 0; cmd_op = 0; cmd_first = 0; cmd_last = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 out_valid idle", int'(out_valid), 0);
    frame("R9", 0, 0, 0, 0);
    frame("R1", 0, 0, 0, 0);
    for (int f = 0; f < 40; f += 3)
      for (int l = f; l < 40; l += 4) begin
        cmd(1, 0, 0); cmd(2, f, l);
        frame("R3", 0, 0, 0, 0);
      end
    for (int f = 0; f < 40; f += 4)
      for (int l = f; l < 40; l += 5) begin
        cmd(1, 0, 0); cmd(2, 0, 39); cmd(3, f, l);
        frame("R4", 0, 0, 0, 0);
      end
    cmd(1, 0, 0); cmd(2, 0, 4); cmd(2, 10, 12); cmd(2, 3, 11);
    frame("R3", 0, 0, 0, 0);
    cmd(1, 0, 0);
    frame("R2", 0, 0, 0, 0);
    cmd(2, 5, 25); cmd(2, 30, 6); cmd(3, 20, 8);
    frame("R7", 0, 0, 0, 0);
    cmd(0, 0, 39); cmd(6, 0, 39); cmd(7, 0, 39);
    frame("R7", 0, 0, 0, 0);
    cmd(5, 0, 0);
    frame("R5", 0, 0, 0, 0);
    frame("R5", 0, 0, 0, 0);
    cmd(4, 0, 0);
    frame("R6", 0, 0, 0, 0);
    frame("R8", 0, 2, 30, 39);
    frame("R8", 0, 3, 0, 39);
    frame("R8", 0, 0, 0, 0);
    cmd(2, 0, 39);
    frame("R10", 1, 0, 0, 0);
    frame("R10", 2, 0, 0, 0);
    cmd(3, 10, 29);
    frame("R11", 3, 0, 0, 0);
    frame("R11", 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule